// File: doc/BRIEF.md
# Maskable Interrupt Status Controller

This block gathers five event sources into a sticky status register and raises a single interrupt line whenever an enabled status bit is set. Bit 0 is set by a rising edge on a level-sensitive core interrupt input. Bits 1 to 4 are set by single-cycle pulses from four other event sources: hot-plug rise, hot-plug fall, nonce-refresh rise and random-number error. The logic that produces those events is outside this block.

Software reaches the block through a simple register port. Writes take effect on the clock edge. Reads are combinational from the address. Three registers are mapped:

- A per-source enable register.
- A status register. Writing 1 to a bit forces that bit on, for test. The top read bit shows the live level of the core interrupt.
- A write-1-to-clear register. This is the only way to clear status bits.

When a hardware event and a clear reach the same bit in the same cycle, the event wins. No event is lost.

The reset input is asserted asynchronously and released synchronously inside the block.

Top module: `irq_status_ctrl`

## Requirements
- R1: After reset the enable register reads 0, the status register reads 0 in bits 0 to 4, and `irq_o` is 0.
- R2: A write to address 0 loads the enable register from `reg_wdata_i[4:0]`. A read of address 0 returns that value in bits 4:0 and zero in every other bit.
- R3: A one-cycle pulse on `evt_i[k]` (k = 0 to 3) sets status bit k+1 at the next clock edge. The bit stays set until it is cleared.
- R4: Status bit 0 is set by a rising edge of `core_irq_i`. If `core_irq_i` stays high, a cleared bit 0 is not set again.
- R5: A write to address 1 sets every status bit whose data bit is 1. Data bits that are 0 leave their status bits unchanged.
- R6: A write to address 2 clears every status bit whose data bit is 1. Data bits that are 0 leave their status bits unchanged. A read of address 2 returns 0.
- R7: If a hardware event and a clear of the same status bit happen in the same cycle, the bit ends up set.
- R8: `irq_o` is 1 exactly when at least one status bit and its enable bit are both 1.
- R9: Bit 31 of a status read (address 1) shows the current level of `core_irq_i`. Bits 30 to 5 read 0.
- R10: Addresses 3 and above read 0. Writes to them change neither the enable register nor the status register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset; released synchronously inside the block |
| core_irq_i | input | 1 | Core interrupt level; its rising edge sets status bit 0 |
| evt_i | input | 4 | One-cycle event pulses for status bits 1 to 4 |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | 4 | Register address: 0 enable, 1 status, 2 clear |
| reg_wdata_i | input | 5 | Write data, one bit per source |
| reg_rdata_o | output | 32 | Combinational read data for `reg_addr_i` |
| irq_o | output | 1 | Combined interrupt output |

## Verification
The assertions assume that `core_irq_i` and `evt_i` are synchronous to `clk_i`. They also assume that `core_irq_i` is low while reset is released, so the edge detector does not report a false rising edge on the first cycle. The stimulus changes every input only on the falling clock edge and holds `core_irq_i` low through reset. It also issues at most one register write per cycle, so a set and a clear from software never collide; only the event-versus-clear collision of R7 is driven deliberately.

// File: rtl/irq_status_pkg.sv
package irq_status_pkg;

  localparam int unsigned NUM_SRC_DEF = 5;
  localparam int unsigned DATA_W_DEF  = 32;
  localparam int unsigned ADDR_W_DEF  = 4;

  // Register map; software drivers decode these offsets
  localparam int unsigned ADDR_ENABLE = 0;
  localparam int unsigned ADDR_STATUS = 1;
  localparam int unsigned ADDR_CLEAR  = 2;

  typedef struct packed {
    logic en_we;
    logic set_we;
    logic clr_we;
  } wr_sel_t;

endpackage

// File: rtl/irq_rst_sync.sv
module irq_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic rst_no
);

  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_q <= '0;
    else         sync_q <= sync_d;
  end

  assign rst_no = sync_q[STAGES-1];

endmodule

// File: rtl/irq_edge_rise.sv
module irq_edge_rise (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic level_i,
  output logic rise_o
);

  logic level_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) level_q <= 1'b0;
    else         level_q <= level_i;
  end

  assign rise_o = level_i & ~level_q;

endmodule

// File: rtl/irq_status_bank.sv
module irq_status_bank #(
  parameter int unsigned NUM_SRC = 5
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_SRC-1:0] hw_set_i,
  input  logic [NUM_SRC-1:0] sw_set_i,
  input  logic [NUM_SRC-1:0] sw_clr_i,
  output logic [NUM_SRC-1:0] stat_o
);

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_bit
    logic bit_q;
    logic bit_d;
    logic bit_en;

    // Hardware set dominates a clear in the same cycle
    always_comb begin
      bit_en = hw_set_i[i] | sw_set_i[i] | sw_clr_i[i];
      bit_d  = bit_q;
      if (sw_clr_i[i])                bit_d = 1'b0;
      if (hw_set_i[i] | sw_set_i[i])  bit_d = 1'b1;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)     bit_q <= 1'b0;
      else if (bit_en) bit_q <= bit_d;
    end

    assign stat_o[i] = bit_q;
  end

endmodule

// File: rtl/irq_reg_port.sv
module irq_reg_port
  import irq_status_pkg::*;
#(
  parameter int unsigned NUM_SRC = 5,
  parameter int unsigned ADDR_W  = 4,
  parameter int unsigned DATA_W  = 32
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               wr_i,
  input  logic [ADDR_W-1:0]  addr_i,
  input  logic [NUM_SRC-1:0] wdata_i,
  input  logic [NUM_SRC-1:0] stat_i,
  input  logic               core_live_i,
  output logic [NUM_SRC-1:0] enable_o,
  output logic [NUM_SRC-1:0] set_o,
  output logic [NUM_SRC-1:0] clr_o,
  output logic [DATA_W-1:0]  rdata_o
);

  localparam int unsigned LIVE_BIT = DATA_W - 1;

  wr_sel_t            sel;
  logic [NUM_SRC-1:0] enable_q;
  logic [NUM_SRC-1:0] enable_d;

  always_comb begin
    sel.en_we  = wr_i && (addr_i == ADDR_W'(ADDR_ENABLE));
    sel.set_we = wr_i && (addr_i == ADDR_W'(ADDR_STATUS));
    sel.clr_we = wr_i && (addr_i == ADDR_W'(ADDR_CLEAR));
    enable_d   = wdata_i;
    set_o      = sel.set_we ? wdata_i : '0;
    clr_o      = sel.clr_we ? wdata_i : '0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         enable_q <= '0;
    else if (sel.en_we)  enable_q <= enable_d;
  end

  always_comb begin
    rdata_o = '0;
    if (addr_i == ADDR_W'(ADDR_ENABLE)) begin
      rdata_o[NUM_SRC-1:0] = enable_q;
    end else if (addr_i == ADDR_W'(ADDR_STATUS)) begin
      rdata_o[NUM_SRC-1:0] = stat_i;
      rdata_o[LIVE_BIT]    = core_live_i;
    end
  end

  assign enable_o = enable_q;

endmodule

// File: rtl/irq_status_ctrl.sv
module irq_status_ctrl
  import irq_status_pkg::*;
#(
  parameter int unsigned NUM_SRC = NUM_SRC_DEF,
  parameter int unsigned ADDR_W  = ADDR_W_DEF,
  parameter int unsigned DATA_W  = DATA_W_DEF
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               core_irq_i,
  input  logic [NUM_SRC-2:0] evt_i,
  input  logic               reg_wr_i,
  input  logic [ADDR_W-1:0]  reg_addr_i,
  input  logic [NUM_SRC-1:0] reg_wdata_i,
  output logic [DATA_W-1:0]  reg_rdata_o,
  output logic               irq_o
);

  logic               rst_sync_n;
  logic               core_rise;
  logic [NUM_SRC-1:0] evt_full;
  logic [NUM_SRC-1:0] stat_q;
  logic [NUM_SRC-1:0] mask_q;
  logic [NUM_SRC-1:0] sw_set;
  logic [NUM_SRC-1:0] sw_clr;

  irq_rst_sync #(.STAGES(2)) u_rst (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .rst_no (rst_sync_n)
  );

  irq_edge_rise u_core_edge (
    .clk_i   (clk_i),
    .rst_ni  (rst_sync_n),
    .level_i (core_irq_i),
    .rise_o  (core_rise)
  );

  assign evt_full = {evt_i, core_rise};

  irq_reg_port #(.NUM_SRC(NUM_SRC), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_port (
    .clk_i       (clk_i),
    .rst_ni      (rst_sync_n),
    .wr_i        (reg_wr_i),
    .addr_i      (reg_addr_i),
    .wdata_i     (reg_wdata_i),
    .stat_i      (stat_q),
    .core_live_i (core_irq_i),
    .enable_o    (mask_q),
    .set_o       (sw_set),
    .clr_o       (sw_clr),
    .rdata_o     (reg_rdata_o)
  );

  irq_status_bank #(.NUM_SRC(NUM_SRC)) u_bank (
    .clk_i    (clk_i),
    .rst_ni   (rst_sync_n),
    .hw_set_i (evt_full),
    .sw_set_i (sw_set),
    .sw_clr_i (sw_clr),
    .stat_o   (stat_q)
  );

  assign irq_o = |(stat_q & mask_q);

endmodule

// File: rtl/irq_status_ctrl_chk.sv
module irq_status_ctrl_chk
  import irq_status_pkg::*;
#(
  parameter int unsigned NUM_SRC = 5,
  parameter int unsigned ADDR_W  = 4
) (
  input logic               clk_i,
  input logic               rst_sync_n,
  input logic               core_irq_i,
  input logic               reg_wr_i,
  input logic [ADDR_W-1:0]  reg_addr_i,
  input logic [NUM_SRC-1:0] reg_wdata_i,
  input logic [NUM_SRC-1:0] evt_full,
  input logic [NUM_SRC-1:0] stat_q,
  input logic [NUM_SRC-1:0] mask_q,
  input logic               irq_o
);

  logic               wr_en, wr_set, wr_clr;
  logic [NUM_SRC-1:0] cause;

  always_comb begin
    wr_en  = reg_wr_i && (reg_addr_i == ADDR_W'(ADDR_ENABLE));
    wr_set = reg_wr_i && (reg_addr_i == ADDR_W'(ADDR_STATUS));
    wr_clr = reg_wr_i && (reg_addr_i == ADDR_W'(ADDR_CLEAR));
    cause  = evt_full | (wr_set ? reg_wdata_i : '0);
  end

  // R2: enable register takes the written value
  a_r2_enable_load: assert property (@(posedge clk_i) disable iff (!rst_sync_n)
    wr_en |=> mask_q == $past(reg_wdata_i));

  // R3 and R7: every event leaves its status bit set, even against a clear
  a_r3_event_sets: assert property (@(posedge clk_i) disable iff (!rst_sync_n)
    (evt_full != '0) |=> ((stat_q & $past(evt_full)) == $past(evt_full)));

  // R4: a rising core level sets bit 0
  a_r4_core_edge: assert property (@(posedge clk_i) disable iff (!rst_sync_n)
    $rose(core_irq_i) |=> stat_q[0]);

  // R5: no status bit turns on without an event or a software set
  a_r5_no_spurious_set: assert property (@(posedge clk_i) disable iff (!rst_sync_n)
    (stat_q & ~$past(stat_q) & ~$past(cause)) == '0);

  // R6: a clear without a competing event empties the selected bits
  a_r6_clear_works: assert property (@(posedge clk_i) disable iff (!rst_sync_n)
    wr_clr |=> (stat_q & $past(reg_wdata_i & ~evt_full)) == '0);

  // R8: nothing enabled means no interrupt
  a_r8_quiet_when_masked: assert property (@(posedge clk_i) disable iff (!rst_sync_n)
    (mask_q == '0) |-> !irq_o);

  // R8: a set, enabled bit must raise the interrupt
  a_r8_raise_when_enabled: assert property (@(posedge clk_i) disable iff (!rst_sync_n)
    ((stat_q & mask_q) != '0) |-> irq_o);

endmodule

bind irq_status_ctrl irq_status_ctrl_chk #(.NUM_SRC(NUM_SRC), .ADDR_W(ADDR_W)) u_chk (
  .clk_i       (clk_i),
  .rst_sync_n  (rst_sync_n),
  .core_irq_i  (core_irq_i),
  .reg_wr_i    (reg_wr_i),
  .reg_addr_i  (reg_addr_i),
  .reg_wdata_i (reg_wdata_i),
  .evt_full    (evt_full),
  .stat_q      (stat_q),
  .mask_q      (mask_q),
  .irq_o       (irq_o)
);

// File: tb/irq_status_ctrl_bench.sv
module irq_status_ctrl_bench;

  localparam int CLK_PERIOD = 10;
  localparam logic [3:0] A_EN  = 4'd0;
  localparam logic [3:0] A_ST  = 4'd1;
  localparam logic [3:0] A_CLR = 4'd2;

  logic        clk = 1'b0;
  logic        rst_ni;
  logic        core_irq;
  logic [3:0]  evt;
  logic        reg_wr;
  logic [3:0]  reg_addr;
  logic [4:0]  reg_wdata;
  logic [31:0] reg_rdata;
  logic        irq;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  irq_status_ctrl u_irq_status_ctrl (
    .clk_i       (clk),
    .rst_ni      (rst_ni),
    .core_irq_i  (core_irq),
    .evt_i       (evt),
    .reg_wr_i    (reg_wr),
    .reg_addr_i  (reg_addr),
    .reg_wdata_i (reg_wdata),
    .reg_rdata_o (reg_rdata),
    .irq_o       (irq)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Called at a falling edge; returns at the next one, after the write edge
  task automatic wr(input logic [3:0] a, input logic [4:0] d);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0; reg_wdata = '0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    reg_addr = a;
    #1;
    d = reg_rdata;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [31:0] d;
    rst_ni = 1'b0; core_irq = 1'b0; evt = '0;
    reg_wr = 1'b0; reg_addr = '0; reg_wdata = '0;
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    repeat (3) @(negedge clk);

    // R1 reset state
    rd(A_EN, d); check("R1 enable", d, 32'h0);
    rd(A_ST, d); check("R1 status", d, 32'h0);
    check("R1 irq", {31'b0, irq}, 32'h0);

    // R8, R5, R2 sweep: every status pattern against every enable pattern
    for (int s = 0; s < 32; s++) begin
      for (int m = 0; m < 32; m++) begin
        wr(A_CLR, 5'h1F);
        wr(A_ST, 5'(s));
        wr(A_EN, 5'(m));
        check("R8 irq", {31'b0, irq}, {31'b0, ((s & m) != 0)});
        rd(A_ST, d); check("R5 status set", d, 32'(s));
        rd(A_EN, d); check("R2 enable read", d, 32'(m));
      end
    end

    // R6 sweep: every status pattern against every clear pattern
    for (int s = 0; s < 32; s++) begin
      for (int c = 0; c < 32; c++) begin
        wr(A_CLR, 5'h1F);
        wr(A_ST, 5'(s));
        wr(A_CLR, 5'(c));
        rd(A_ST, d); check("R6 clear", d, 32'(s & ~c & 31));
      end
    end
    rd(A_CLR, d); check("R6 clear reads zero", d, 32'h0);

    // R3 event pulses, all combinations, sticky afterwards
    for (int e = 1; e < 16; e++) begin
      wr(A_CLR, 5'h1F);
      evt = 4'(e);
      @(negedge clk);
      evt = '0;
      rd(A_ST, d); check("R3 event sets", d, 32'(e << 1));
      @(negedge clk);
      rd(A_ST, d); check("R3 event sticky", d, 32'(e << 1));
    end

    // R5 and R6: zero writes have no effect
    wr(A_CLR, 5'h1F);
    wr(A_ST, 5'h15);
    wr(A_ST, 5'h00);
    rd(A_ST, d); check("R5 zero write", d, 32'h15);
    wr(A_CLR, 5'h00);
    rd(A_ST, d); check("R6 zero clear", d, 32'h15);

    // R10 unmapped addresses
    wr(A_EN, 5'h0A);
    for (int a = 3; a < 16; a++) begin
      wr(4'(a), 5'h1F);
      rd(4'(a), d); check("R10 unmapped read", d, 32'h0);
      rd(A_ST, d); check("R10 status kept", d, 32'h15);
      rd(A_EN, d); check("R10 enable kept", d, 32'h0A);
    end

    // R4 core edge and R9 live bit
    wr(A_CLR, 5'h1F);
    core_irq = 1'b1;
    @(negedge clk);
    rd(A_ST, d); check("R4 edge sets bit0 / R9 live high", d, 32'h8000_0001);
    wr(A_CLR, 5'h01);
    @(negedge clk);
    rd(A_ST, d); check("R4 held level no reset", d, 32'h8000_0000);
    core_irq = 1'b0;
    @(negedge clk);
    rd(A_ST, d); check("R9 live low", d, 32'h0);

    // R7 core edge against clear
    core_irq = 1'b1;
    wr(A_CLR, 5'h1F);
    rd(A_ST, d); check("R7 core edge beats clear", d, 32'h8000_0001);
    // R7 pulse event against clear
    evt = 4'b0010;
    wr(A_CLR, 5'h1F);
    evt = '0;
    rd(A_ST, d); check("R7 event beats clear", d, 32'h8000_0004);
    core_irq = 1'b0;
    @(negedge clk);
    wr(A_EN, 5'h04);
    check("R8 enabled event irq", {31'b0, irq}, 32'h1);
    wr(A_CLR, 5'h04);
    check("R8 irq drops", {31'b0, irq}, 32'h0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule